// File: doc/BRIEF.md
# Precision-Aliased Floating-Point Register File

This block stores floating-point operands in one shared pool of 32-bit words and lets a client reach that pool through three views. A single-precision access covers one word, a double-precision access covers two adjacent words, and a quad-precision access covers four. All three views alias the same storage bits, so a value written as a double can be read back as two singles or as half of a quad. An optional extended bank adds a second set of 32 words. That bank is reachable only through the double and quad views.

There is one write port and one read port. Each port carries a 6-bit register number in single-word units and a 2-bit precision code. Both ports share a 128-bit data path. Narrower accesses use the low end of the bus, and the unused upper bits read as zero. Reads are combinational from storage. Writes commit at the rising clock edge and change only the words they cover. The block decodes every access for legality. It raises a per-port error flag on an illegal access, returns zero data for an illegal read, and drops an illegal write.

Top module: `fp_alias_regfile`

## Requirements
- R1: While reset is asserted, and after it is released, every word of storage is zero, so a legal read of any view returns all-zero data.
- R2: Precision code 0 selects a single: register number s (0 to 31) is word s, returned on rd_data[31:0], with rd_data[127:32] zero.
- R3: Precision code 1 selects a double: even number n covers words n and n+1. Word n (the even single) appears on bits [63:32] and word n+1 on bits [31:0], with rd_data[127:64] zero.
- R4: Precision code 2 selects a quad: number q, a multiple of 4, covers words q to q+3. Word q appears on bits [127:96], q+1 on [95:64], q+2 on [63:32] and q+3 on [31:0].
- R5: A legal write replaces exactly the words its view covers, taking them from the same bit positions a read of that view would return. All other words, including the other half of a double written as a single, keep their values.
- R6: A write takes effect at the rising clock edge. A read in the same cycle as an overlapping write returns the old content, and the new content is visible from the next cycle.
- R7: The following accesses are illegal: precision code 3, a double with an odd number, a quad with a number not a multiple of 4, and a single with a number of 32 or more. An illegal read sets rd_err and returns all-zero rd_data.
- R8: An illegal write with wr_en high sets wr_err in the same cycle and leaves all storage unchanged. wr_err is low whenever wr_en is low.
- R9: With EXT_BANK=1, doubles numbered 32 to 62 and quads numbered 32 to 60 are legal and address storage distinct from the base words 0 to 31. With EXT_BANK=0, those numbers are illegal for every precision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, clears storage |
| wr_en | input | 1 | Write request |
| wr_num | input | 6 | Write register number, in single-word units |
| wr_prec | input | 2 | Write precision: 0 single, 1 double, 2 quad, 3 illegal |
| wr_data | input | 128 | Write data, low-aligned to the view width |
| wr_err | output | 1 | Illegal write flag, valid in the request cycle |
| rd_num | input | 6 | Read register number, in single-word units |
| rd_prec | input | 2 | Read precision, same coding as wr_prec |
| rd_data | output | 128 | Read data, low-aligned, upper bits zero |
| rd_err | output | 1 | Illegal read flag |

## Verification
A write and a read can fall in the same cycle and touch overlapping words through different views. For example, a single is written while the enclosing double or quad is read. The bench provokes this in directed steps and again in a long random stretch where both ports are active on every cycle. It judges each cycle against a flat word-array model that is read before the model applies that cycle's write, so the old-data-then-new behaviour of R6 and the aliasing of R2 to R5 are checked together. A second instance built without the extended bank receives the same stimulus, and only its error flags are compared.

// File: rtl/fprf_pkg.sv
package fprf_pkg;

    typedef enum logic [1:0] {
        PREC_SGL = 2'd0,
        PREC_DBL = 2'd1,
        PREC_QUAD = 2'd2,
        PREC_BAD = 2'd3
    } prec_e;

    // Span of a view minus one, in words: 0, 1 or 3.
    function automatic logic [1:0] span_of(input prec_e p);
        unique case (p)
            PREC_SGL:  return 2'd0;
            PREC_DBL:  return 2'd1;
            PREC_QUAD: return 2'd3;
            default:   return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/fprf_decode.sv
module fprf_decode
    import fprf_pkg::*;
#(
    parameter int NWORD = 64,
    parameter int NSGL  = 32,
    parameter int NUM_W = 6
) (
    input  logic [NUM_W-1:0] num,
    input  logic [1:0]       prec,
    output logic             legal,
    output logic [1:0]       span
);

    prec_e p;

    always_comb begin
        p    = prec_e'(prec);
        span = span_of(p);
        unique case (p)
            PREC_SGL:  legal = int'(num) < NSGL;
            PREC_DBL:  legal = !num[0] && (int'(num) + 1 < NWORD);
            PREC_QUAD: legal = (num[1:0] == 2'b00) && (int'(num) + 3 < NWORD);
            default:   legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/fprf_store.sv
module fprf_store #(
    parameter int WORD_W = 32,
    parameter int NWORD  = 64,
    parameter int NUM_W  = 6,
    localparam int DATA_W = 4 * WORD_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [NUM_W-1:0]        wnum,
    input  logic [1:0]              wspan,
    input  logic [DATA_W-1:0]       wdata,
    output logic [NWORD*WORD_W-1:0] words
);

    logic [NUM_W-1:0] span_ext;
    assign span_ext = {{(NUM_W-2){1'b0}}, wspan};

    for (genvar w = 0; w < NWORD; w++) begin : g_word
        localparam logic [NUM_W-1:0] WI = NUM_W'(w);
        logic       hit;
        logic [1:0] lane;

        // Word lies inside the aligned group addressed by wnum.
        assign hit  = we && (((WI ^ wnum) & ~span_ext) == '0);
        // Lowest word of the group maps to the most significant lane.
        assign lane = ~WI[1:0] & wspan;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                words[w*WORD_W +: WORD_W] <= '0;
            end else if (hit) begin
                words[w*WORD_W +: WORD_W] <= wdata[lane*WORD_W +: WORD_W];
            end
        end
    end

endmodule

// File: rtl/fprf_rdmux.sv
module fprf_rdmux #(
    parameter int WORD_W = 32,
    parameter int NWORD  = 64,
    parameter int NUM_W  = 6,
    localparam int DATA_W = 4 * WORD_W,
    localparam int IDX_W  = $clog2(NWORD)
) (
    input  logic [NWORD*WORD_W-1:0] words,
    input  logic [NUM_W-1:0]        rnum,
    input  logic [1:0]              rspan,
    input  logic                    rlegal,
    output logic [DATA_W-1:0]       rdata
);

    logic [WORD_W-1:0] warr [NWORD];

    for (genvar w = 0; w < NWORD; w++) begin : g_unpack
        assign warr[w] = words[w*WORD_W +: WORD_W];
    end

    for (genvar l = 0; l < 4; l++) begin : g_lane
        localparam logic [1:0] LI = 2'(l);
        logic [NUM_W-1:0] idx;
        logic [IDX_W-1:0] idx_lo;
        logic             used;

        assign idx    = rnum | {{(NUM_W-2){1'b0}}, rspan & ~LI};
        assign idx_lo = idx[IDX_W-1:0];
        assign used   = rlegal && (LI <= rspan);
        assign rdata[l*WORD_W +: WORD_W] = used ? warr[idx_lo] : '0;
    end

endmodule

// File: rtl/fp_alias_regfile.sv
module fp_alias_regfile
    import fprf_pkg::*;
#(
    parameter bit EXT_BANK = 1'b1,
    parameter int WORD_W   = 32,
    parameter int BASE_DBL = 16,
    localparam int NSGL   = 2 * BASE_DBL,
    localparam int NWORD  = EXT_BANK ? 2 * NSGL : NSGL,
    localparam int NUM_W  = $clog2(4 * BASE_DBL),
    localparam int DATA_W = 4 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [NUM_W-1:0]  wr_num,
    input  logic [1:0]        wr_prec,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_err,
    input  logic [NUM_W-1:0]  rd_num,
    input  logic [1:0]        rd_prec,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_err
);

    logic                    wr_legal;
    logic                    rd_legal;
    logic [1:0]              wr_span;
    logic [1:0]              rd_span;
    logic [NWORD*WORD_W-1:0] words;

    fprf_decode #(.NWORD(NWORD), .NSGL(NSGL), .NUM_W(NUM_W)) u_wdec (
        .num   (wr_num),
        .prec  (wr_prec),
        .legal (wr_legal),
        .span  (wr_span)
    );

    fprf_decode #(.NWORD(NWORD), .NSGL(NSGL), .NUM_W(NUM_W)) u_rdec (
        .num   (rd_num),
        .prec  (rd_prec),
        .legal (rd_legal),
        .span  (rd_span)
    );

    fprf_store #(.WORD_W(WORD_W), .NWORD(NWORD), .NUM_W(NUM_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en && wr_legal),
        .wnum  (wr_num),
        .wspan (wr_span),
        .wdata (wr_data),
        .words (words)
    );

    fprf_rdmux #(.WORD_W(WORD_W), .NWORD(NWORD), .NUM_W(NUM_W)) u_rdmux (
        .words  (words),
        .rnum   (rd_num),
        .rspan  (rd_span),
        .rlegal (rd_legal),
        .rdata  (rd_data)
    );

    assign wr_err = wr_en && !wr_legal;
    assign rd_err = !rd_legal;

endmodule

// File: rtl/fprf_props.sv
module fprf_props #(
    parameter int WORD_W = 32,
    parameter int NWORD  = 64,
    parameter int NUM_W  = 6,
    localparam int DATA_W = 4 * WORD_W
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_en,
    input logic [NUM_W-1:0]        wr_num,
    input logic [1:0]              wr_prec,
    input logic [DATA_W-1:0]       wr_data,
    input logic                    wr_err,
    input logic [NUM_W-1:0]        rd_num,
    input logic [1:0]              rd_prec,
    input logic [DATA_W-1:0]       rd_data,
    input logic                    rd_err,
    input logic [NWORD*WORD_W-1:0] words
);

    function automatic logic [DATA_W-1:0] keep_of(input logic [1:0] p);
        unique case (p)
            2'd0:    return {{(DATA_W-WORD_W){1'b0}}, {WORD_W{1'b1}}};
            2'd1:    return {{(DATA_W-2*WORD_W){1'b0}}, {(2*WORD_W){1'b1}}};
            default: return {DATA_W{1'b1}};
        endcase
    endfunction

    AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> (rd_data == '0)); // R7

    AST_SGL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_prec == 2'd0 && !rd_err) |-> (rd_data[DATA_W-1:WORD_W] == '0)); // R2

    AST_DBL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_prec == 2'd1 && !rd_err) |-> (rd_data[DATA_W-1:2*WORD_W] == '0)); // R3

    AST_ODD_DBL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_prec == 2'd1 && rd_num[0]) |-> rd_err); // R7

    AST_BAD_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |=> $stable(words)); // R8

    AST_IDLE_NO_WERR: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> !wr_err); // R8

    AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_err) |=>
            ((rd_num != $past(wr_num)) || (rd_prec != $past(wr_prec)) ||
             (rd_data == ($past(wr_data) & keep_of($past(wr_prec)))))); // R6

endmodule

bind fp_alias_regfile fprf_props #(
    .WORD_W (WORD_W),
    .NWORD  (NWORD),
    .NUM_W  (NUM_W)
) u_props (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_num  (wr_num),
    .wr_prec (wr_prec),
    .wr_data (wr_data),
    .wr_err  (wr_err),
    .rd_num  (rd_num),
    .rd_prec (rd_prec),
    .rd_data (rd_data),
    .rd_err  (rd_err),
    .words   (words)
);

// File: tb/fp_alias_regfile_test.sv
module fp_alias_regfile_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [5:0]   wr_num = '0;
    logic [1:0]   wr_prec = '0;
    logic [127:0] wr_data = '0;
    logic [5:0]   rd_num = '0;
    logic [1:0]   rd_prec = '0;
    logic         wr_err, rd_err, nx_wr_err, nx_rd_err;
    logic [127:0] rd_data, nx_rd_data;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    logic [31:0] mdl [64];

    always #4 clk = ~clk;

    fp_alias_regfile #(.EXT_BANK(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_num(wr_num),
        .wr_prec(wr_prec), .wr_data(wr_data), .wr_err(wr_err),
        .rd_num(rd_num), .rd_prec(rd_prec), .rd_data(rd_data), .rd_err(rd_err)
    );

    fp_alias_regfile #(.EXT_BANK(1'b0)) uut_nx (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_num(wr_num),
        .wr_prec(wr_prec), .wr_data(wr_data), .wr_err(nx_wr_err),
        .rd_num(rd_num), .rd_prec(rd_prec), .rd_data(nx_rd_data), .rd_err(nx_rd_err)
    );

    function automatic int cnt_of(input logic [1:0] p);
        return (p == 2'd2) ? 4 : (p == 2'd1) ? 2 : 1;
    endfunction

    function automatic bit m_legal(input logic [5:0] n, input logic [1:0] p, input bit ext);
        int nw = ext ? 64 : 32;
        case (p)
            2'd0:    return int'(n) < 32;
            2'd1:    return (n % 2 == 0) && (int'(n) + 1 < nw);
            2'd2:    return (n % 4 == 0) && (int'(n) + 3 < nw);
            default: return 0;
        endcase
    endfunction

    function automatic logic [127:0] m_read(input logic [5:0] n, input logic [1:0] p);
        logic [127:0] r = '0;
        int c = cnt_of(p);
        if (!m_legal(n, p, 1)) return '0;
        for (int l = 0; l < c; l++) r[l*32 +: 32] = mdl[int'(n) + c - 1 - l];
        return r;
    endfunction

    task automatic check(input bit ok, input string what, input string tag,
                         input logic [127:0] act, input logic [127:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        logic [127:0] e = m_read(rd_num, rd_prec);
        bit el = m_legal(rd_num, rd_prec, 1);
        bit ew = wr_en && !m_legal(wr_num, wr_prec, 1);
        check(rd_data === e, "rd_data", tag, rd_data, e);
        check(rd_err === !el, "rd_err", tag, 128'(rd_err), 128'(!el));
        check(wr_err === ew, "wr_err", tag, 128'(wr_err), 128'(ew));
        check(nx_rd_err === !m_legal(rd_num, rd_prec, 0), "nx rd_err R9", tag,
              128'(nx_rd_err), 128'(!m_legal(rd_num, rd_prec, 0)));
        check(nx_wr_err === (wr_en && !m_legal(wr_num, wr_prec, 0)), "nx wr_err R9", tag,
              128'(nx_wr_err), 128'(wr_en && !m_legal(wr_num, wr_prec, 0)));
    endtask

    // One cycle: drive at falling edge, compare before the rising edge,
    // then apply this cycle's write to the model.
    task automatic step(input bit we, input logic [5:0] wn, input logic [1:0] wp,
                        input logic [127:0] wd, input logic [5:0] rn,
                        input logic [1:0] rp, input string tag);
        @(negedge clk);
        wr_en = we; wr_num = wn; wr_prec = wp; wr_data = wd;
        rd_num = rn; rd_prec = rp;
        #1;
        compare(tag);
        if (we && m_legal(wn, wp, 1)) begin
            int c = cnt_of(wp);
            for (int j = 0; j < c; j++) mdl[int'(wn) + j] = wd[(c - 1 - j)*32 +: 32];
        end
    endtask

    task automatic rd(input logic [5:0] rn, input logic [1:0] rp, input string tag);
        step(0, 6'd0, 2'd0, '0, rn, rp, tag);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog expired act=hung exp=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) mdl[i] = '0;
        // R1: reset state, reads taken while reset is still asserted
        @(negedge clk);
        rd_num = 6'd60; rd_prec = 2'd2;
        #1;
        check(rd_data === '0, "rd_data in reset", "R1", rd_data, '0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd(6'd0, 2'd2, "R1");
        rd(6'd60, 2'd2, "R1");
        rd(6'd34, 2'd1, "R1");

        // R2 / R5: singles land in their half of the enclosing double
        step(1, 6'd5, 2'd0, {96'hdead_beef_0000_1111_2222_3333, 32'haaaa_5555}, 6'd5, 2'd0, "R2");
        rd(6'd5, 2'd0, "R2");
        rd(6'd4, 2'd1, "R5");
        step(1, 6'd4, 2'd0, 128'h1234_5678, 6'd4, 2'd2, "R5");
        rd(6'd4, 2'd1, "R3");
        rd(6'd4, 2'd2, "R4");

        // R3: double write seen through singles and quad
        step(1, 6'd10, 2'd1, {64'hffff_ffff_ffff_ffff, 64'h0102_0304_0506_0708}, 6'd10, 2'd1, "R3");
        rd(6'd10, 2'd0, "R3");
        rd(6'd11, 2'd0, "R3");
        rd(6'd8, 2'd2, "R4");

        // R4: quad write seen through doubles and singles
        step(1, 6'd16, 2'd2, 128'h0f0e0d0c_0b0a0908_07060504_03020100, 6'd16, 2'd2, "R4");
        rd(6'd16, 2'd1, "R4");
        rd(6'd18, 2'd1, "R4");
        rd(6'd16, 2'd0, "R4");
        rd(6'd19, 2'd0, "R4");

        // R9: extended bank, distinct from base words
        step(1, 6'd40, 2'd1, 128'hcafe_f00d_bead_0042, 6'd40, 2'd1, "R9");
        rd(6'd40, 2'd2, "R9");
        rd(6'd8, 2'd2, "R9");
        step(1, 6'd60, 2'd2, {4{32'h5a5a_a5a5}}, 6'd60, 2'd2, "R9");
        rd(6'd62, 2'd1, "R9");

        // R7: illegal reads
        rd(6'd4, 2'd3, "R7");
        rd(6'd3, 2'd1, "R7");
        rd(6'd6, 2'd2, "R7");
        rd(6'd32, 2'd0, "R7");

        // R8: illegal writes leave storage alone
        step(1, 6'd5, 2'd1, {128{1'b1}}, 6'd4, 2'd2, "R8");
        rd(6'd4, 2'd2, "R8");
        step(1, 6'd18, 2'd2, {128{1'b1}}, 6'd16, 2'd2, "R8");
        rd(6'd16, 2'd2, "R8");
        step(1, 6'd33, 2'd0, {128{1'b1}}, 6'd32, 2'd2, "R8");
        rd(6'd32, 2'd2, "R8");
        step(1, 6'd0, 2'd3, {128{1'b1}}, 6'd0, 2'd2, "R8");
        rd(6'd0, 2'd2, "R8");

        // R6: overlapping read in the write cycle sees old data
        step(1, 6'd21, 2'd0, 128'h7777_8888, 6'd20, 2'd1, "R6");
        rd(6'd20, 2'd1, "R6");
        step(1, 6'd20, 2'd2, 128'h1_2_3_4, 6'd22, 2'd1, "R6");
        rd(6'd20, 2'd2, "R6");

        // Random mix, both ports busy every cycle
        for (int k = 0; k < 600; k++) begin
            step(1'($urandom % 2), 6'($urandom), 2'($urandom),
                 {$urandom, $urandom, $urandom, $urandom},
                 6'($urandom), 2'($urandom), "R5 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule